// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

This block is a register-mapped integrity engine. Software picks one of four CRC polynomials or a 16-bit ones-complement (TCP-style) checksum. It then writes data one word at a time, and each data write updates an internal accumulator in a single clock cycle. The accumulator is exposed as a seed register. Software can preload the seed before a run and read the raw running value from it at any time.

A control register sets how each run behaves. It selects how the accumulator starts (from the seed, all zeros or all ones) and whether each write carries 8 or 32 bits. It also sets how the input bytes are conditioned: bit reversal inside each byte, byte swap inside half-words, and half-word swap. A separate read-only result register shows the accumulator after optional inversion and per-byte bit reversal. The start selection clears itself on the first data write, so the following writes continue the same run.

Registers sit at word addresses 0 (control), 1 (seed), 2 (data in, write only, reads zero) and 3 (result, read only). Writes take effect at the clock edge where the write enable is high. Reads are combinational.

Top module: `crc_sum_engine`

## Requirements
- R1: After reset, the control, seed and result registers all read zero.
- R2: Control bits [3:0] select the operation. 0000 selects CRC polynomial 0x8005 and 0001 selects 0x1021, both 16 bits wide. 0010 selects 0x04C11DB7 and 0011 selects 0x1EDC6F41, both 32 bits wide. 1000 selects the checksum. CRCs shift most significant bit first with no reflection. The 16-bit polynomials and the checksum keep seed bits [31:16] at zero after a data write.
- R3: Control bits [14:13] choose the value the accumulator starts from on a data write: 00 the seed register, 10 all zeros, 11 all ones. Code 01 behaves as 00. For 16-bit operations only the low 16 bits of the start value are used.
- R4: Any data write clears control bits [14:13] to 00 in the same edge, so later writes accumulate until software writes the field again.
- R5: Control bit 12 set to 1 makes a data write process only data bits [7:0]. Set to 0, the write processes all 32 bits, most significant byte first.
- R6: Control bit 7 reverses the bit order within every input byte before processing.
- R7: In 32-bit mode, control bit 4 swaps the two bytes of each half-word and control bit 5 swaps the two half-words. Both act before processing, and both are ignored in 8-bit mode.
- R8: In checksum mode, a 32-bit write adds its upper and lower conditioned half-words to the 16-bit sum, and an 8-bit write adds the conditioned byte. Every carry out of bit 15 is added back into bit 0.
- R9: The result register shows the seed value, inverted over the active width (16 or 32 bits) when control bit 9 is 1, then bit-reversed within each byte when control bit 8 is 1. These bits never change the seed register.
- R10: Writing the seed register loads all 32 bits, and the seed reads back the raw accumulator. The seed changes only on seed writes and data writes.
- R11: A data write under an undefined operation code leaves the seed unchanged. A write to the result address changes nothing. Control bits outside those named above read back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 32 | Combinational read data |

## Verification
The assertions assume that each clock cycle carries at most one register write and that the write address is one of the four defined registers. The write and read ports have no handshake, so the bench drives a write for exactly one cycle and puts any read in cycles without a write. Random stimulus draws operation codes mostly from the five defined codes and only occasionally from an undefined one. It also seeds start selections, swaps and reversals independently, so that combinations of conditioning options meet mid-run. Directed cases cover known check values, the end-around carry and the ignored writes.

// File: rtl/crc_sum_pkg.sv
package crc_sum_pkg;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = WORD_W / 2;
  localparam int NBYTES    = WORD_W / 8;
  localparam int REG_AW    = 2;

  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_SEED = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_DATA = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_RSLT = 2'd3;

  localparam logic [3:0] OP_P16A = 4'h0;
  localparam logic [3:0] OP_P16B = 4'h1;
  localparam logic [3:0] OP_P32A = 4'h2;
  localparam logic [3:0] OP_P32B = 4'h3;
  localparam logic [3:0] OP_SUM  = 4'h8;

  typedef struct packed {
    logic [1:0] initSel;
    logic       byteMode;
    logic       outInv;
    logic       outRev;
    logic       inRev;
    logic       swapHalf;
    logic       swapByte;
    logic [3:0] opSel;
  } cfg_t;

  typedef struct packed {
    logic              seedWr;
    logic              dataWr;
    logic [WORD_W-1:0] wdata;
  } strobe_t;

  function automatic cfg_t unpackCfg(logic [WORD_W-1:0] w);
    cfg_t c;
    c.initSel  = w[14:13];
    c.byteMode = w[12];
    c.outInv   = w[9];
    c.outRev   = w[8];
    c.inRev    = w[7];
    c.swapHalf = w[5];
    c.swapByte = w[4];
    c.opSel    = w[3:0];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] packCfg(cfg_t c);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[14:13] = c.initSel;
    w[12]    = c.byteMode;
    w[9]     = c.outInv;
    w[8]     = c.outRev;
    w[7]     = c.inRev;
    w[5]     = c.swapHalf;
    w[4]     = c.swapByte;
    w[3:0]   = c.opSel;
    return w;
  endfunction

  function automatic logic [7:0] revByte(logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_sum_ctrl.sv
module crc_sum_ctrl
  import crc_sum_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [REG_AW-1:0]    wrAddr,
  input  logic [WORD_W-1:0]    wrData,
  output cfg_t                 cfg,
  output strobe_t              stb,
  output logic [WORD_W-1:0]    ctrlWord
);
  cfg_t cfgQ;
  logic ctrlWr;

  assign ctrlWr     = wrEn && (wrAddr == ADDR_CTRL);
  assign stb.seedWr = wrEn && (wrAddr == ADDR_SEED);
  assign stb.dataWr = wrEn && (wrAddr == ADDR_DATA);
  assign stb.wdata  = wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (ctrlWr) begin
      cfgQ <= unpackCfg(wrData);
    end else if (stb.dataWr) begin
      cfgQ.initSel <= 2'b00;
    end
  end

  assign cfg      = cfgQ;
  assign ctrlWord = packCfg(cfgQ);
endmodule

// File: rtl/crc_sum_dpath.sv
module crc_sum_dpath
  import crc_sum_pkg::*;
#(
  parameter logic [WORD_W-1:0] POLY16_A = 32'h0000_8005,
  parameter logic [WORD_W-1:0] POLY16_B = 32'h0000_1021,
  parameter logic [WORD_W-1:0] POLY32_A = 32'h04C1_1DB7,
  parameter logic [WORD_W-1:0] POLY32_B = 32'h1EDC_6F41
)(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  output logic [WORD_W-1:0] seedQ,
  output logic [WORD_W-1:0] rsltOut
);
  localparam logic [WORD_W-1:0] MASK16 = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  logic              isW16, isW32, isSum, opValid, narrow;
  logic [WORD_W-1:0] poly, startVal, swapped, condWord, nextAcc, actMask;
  logic [WORD_W-1:0] invVal;
  logic [7:0]        lowByte;
  logic [WORD_W-1:0] crcAcc;
  logic [HALF_W-1:0] sumAcc;

  function automatic logic [WORD_W-1:0] crcByte(logic [WORD_W-1:0] acc,
                                                logic [7:0] b, logic w16,
                                                logic [WORD_W-1:0] p);
    logic [WORD_W-1:0] a;
    logic msb;
    a = acc;
    if (w16) a[15:8] = a[15:8] ^ b;
    else     a[31:24] = a[31:24] ^ b;
    for (int k = 0; k < 8; k++) begin
      msb = w16 ? a[15] : a[31];
      a   = {a[WORD_W-2:0], 1'b0};
      if (msb) a = a ^ p;
    end
    if (w16) a[31:16] = '0;
    return a;
  endfunction

  function automatic logic [HALF_W-1:0] onesAdd(logic [HALF_W-1:0] x,
                                                logic [HALF_W-1:0] y);
    logic [HALF_W:0] s;
    s = {1'b0, x} + {1'b0, y};
    return s[HALF_W-1:0] + {{(HALF_W-1){1'b0}}, s[HALF_W]};
  endfunction

  // operation decode
  always_comb begin
    isW16 = (cfg.opSel == OP_P16A) || (cfg.opSel == OP_P16B);
    isW32 = (cfg.opSel == OP_P32A) || (cfg.opSel == OP_P32B);
    isSum = (cfg.opSel == OP_SUM);
    opValid = isW16 || isW32 || isSum;
    narrow  = isW16 || isSum;
    unique case (cfg.opSel)
      OP_P16A: poly = POLY16_A;
      OP_P16B: poly = POLY16_B;
      OP_P32A: poly = POLY32_A;
      OP_P32B: poly = POLY32_B;
      default: poly = '0;
    endcase
    actMask = narrow ? MASK16 : '1;
  end

  // start value selection
  always_comb begin
    unique case (cfg.initSel)
      2'b10:   startVal = '0;
      2'b11:   startVal = '1;
      default: startVal = seedQ;
    endcase
    if (narrow) startVal = startVal & MASK16;
  end

  // input conditioning: swaps first, then per-byte reversal
  always_comb begin
    swapped = stb.wdata;
    if (cfg.swapByte)
      swapped = {swapped[23:16], swapped[31:24], swapped[7:0], swapped[15:8]};
    if (cfg.swapHalf)
      swapped = {swapped[15:0], swapped[31:16]};
  end

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_inRev
    assign condWord[gi*8 +: 8] = cfg.inRev ? revByte(swapped[gi*8 +: 8])
                                           : swapped[gi*8 +: 8];
  end

  assign lowByte = cfg.inRev ? revByte(stb.wdata[7:0]) : stb.wdata[7:0];

  // CRC engine: most significant byte first
  always_comb begin
    crcAcc = startVal;
    if (cfg.byteMode) begin
      crcAcc = crcByte(crcAcc, lowByte, isW16, poly);
    end else begin
      for (int j = NBYTES - 1; j >= 0; j--)
        crcAcc = crcByte(crcAcc, condWord[j*8 +: 8], isW16, poly);
    end
  end

  // ones-complement checksum
  always_comb begin
    if (cfg.byteMode)
      sumAcc = onesAdd(startVal[HALF_W-1:0], {8'h00, lowByte});
    else
      sumAcc = onesAdd(onesAdd(startVal[HALF_W-1:0], condWord[WORD_W-1:HALF_W]),
                       condWord[HALF_W-1:0]);
  end

  always_comb begin
    if (isSum) nextAcc = {{HALF_W{1'b0}}, sumAcc};
    else       nextAcc = crcAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seedQ <= '0;
    end else if (stb.seedWr) begin
      seedQ <= stb.wdata;
    end else if (stb.dataWr && opValid) begin
      seedQ <= nextAcc;
    end
  end

  // post-processed result view
  assign invVal = cfg.outInv ? (seedQ ^ actMask) : seedQ;

  for (genvar go = 0; go < NBYTES; go++) begin : g_outRev
    assign rsltOut[go*8 +: 8] = cfg.outRev ? revByte(invVal[go*8 +: 8])
                                           : invVal[go*8 +: 8];
  end
endmodule

// File: rtl/crc_sum_engine.sv
module crc_sum_engine
  import crc_sum_pkg::*;
#(
  parameter logic [31:0] POLY16_A = 32'h0000_8005,
  parameter logic [31:0] POLY16_B = 32'h0000_1021,
  parameter logic [31:0] POLY32_A = 32'h04C1_1DB7,
  parameter logic [31:0] POLY32_B = 32'h1EDC_6F41
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [1:0]  rdAddr,
  output logic [31:0] rdData
);
  cfg_t              cfgW;
  strobe_t           stbW;
  logic [WORD_W-1:0] ctrlWordW, seedW, rsltW;

  crc_sum_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .cfg      (cfgW),
    .stb      (stbW),
    .ctrlWord (ctrlWordW)
  );

  crc_sum_dpath #(
    .POLY16_A (POLY16_A),
    .POLY16_B (POLY16_B),
    .POLY32_A (POLY32_A),
    .POLY32_B (POLY32_B)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfgW),
    .stb     (stbW),
    .seedQ   (seedW),
    .rsltOut (rsltW)
  );

  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = ctrlWordW;
      ADDR_SEED: rdData = seedW;
      ADDR_RSLT: rdData = rsltW;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/crc_sum_chk.sv
module crc_sum_chk
  import crc_sum_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic [31:0] wrData,
  input logic [1:0]  initSel,
  input logic [3:0]  opSel,
  input logic [31:0] seedVal
);
  logic dataWr, seedWr, narrowOp, validOp;
  assign dataWr   = wrEn && (wrAddr == ADDR_DATA);
  assign seedWr   = wrEn && (wrAddr == ADDR_SEED);
  assign narrowOp = (opSel == OP_P16A) || (opSel == OP_P16B) || (opSel == OP_SUM);
  assign validOp  = narrowOp || (opSel == OP_P32A) || (opSel == OP_P32B);

  // R4
  init_self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> (initSel == 2'b00));

  // R2
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && narrowOp) |=> (seedVal[31:16] == 16'h0000));

  // R10
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedWr |=> (seedVal == $past(wrData)));

  // R10
  seed_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(dataWr || seedWr) |=> $stable(seedVal));

  // R11
  bad_op_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && !validOp) |=> $stable(seedVal));
endmodule

bind crc_sum_engine crc_sum_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .initSel (cfgW.initSel),
  .opSel   (cfgW.opSel),
  .seedVal (seedW)
);

// File: tb/crc_sum_engine_bench.sv
`timescale 1ns/1ps
module crc_sum_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic [1:0]  rdAddr = 2'd0;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mCtl = 32'd0;
  logic [31:0] mAcc = 32'd0;

  crc_sum_engine u_crc_sum_engine (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #2.5 clk = ~clk;

  function automatic bit isNarrow(logic [3:0] op);
    return (op == 4'h0) || (op == 4'h1) || (op == 4'h8);
  endfunction

  function automatic bit isValid(logic [3:0] op);
    return isNarrow(op) || (op == 4'h2) || (op == 4'h3);
  endfunction

  function automatic logic [7:0] flip8(logic [7:0] b);
    return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
  endfunction

  function automatic logic [31:0] refStep(logic [31:0] ctl, logic [31:0] acc,
                                         logic [31:0] d);
    logic [3:0]  op;
    logic [31:0] a, w, poly;
    logic [7:0]  bs [4];
    logic [33:0] s;
    int n;
    bit fb;
    op = ctl[3:0];
    if (!isValid(op)) return acc;
    case (ctl[14:13])
      2'b10:   a = 32'h0;
      2'b11:   a = 32'hFFFF_FFFF;
      default: a = acc;
    endcase
    if (isNarrow(op)) a = a & 32'h0000_FFFF;
    if (ctl[12]) begin
      n = 1; bs[0] = d[7:0];
    end else begin
      w = d;
      if (ctl[4]) w = {w[23:16], w[31:24], w[7:0], w[15:8]};
      if (ctl[5]) w = {w[15:0], w[31:16]};
      n = 4; bs[0] = w[31:24]; bs[1] = w[23:16]; bs[2] = w[15:8]; bs[3] = w[7:0];
    end
    if (ctl[7]) for (int i = 0; i < n; i++) bs[i] = flip8(bs[i]);
    if (op == 4'h8) begin
      if (n == 1) s = {2'b0, a} + {26'b0, bs[0]};
      else s = {2'b0, a} + {18'b0, bs[0], bs[1]} + {18'b0, bs[2], bs[3]};
      while (s > 34'h0FFFF) s = (s & 34'h0FFFF) + (s >> 16);
      return s[31:0];
    end
    case (op)
      4'h0: poly = 32'h8005;
      4'h1: poly = 32'h1021;
      4'h2: poly = 32'h04C11DB7;
      default: poly = 32'h1EDC6F41;
    endcase
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        fb = isNarrow(op) ? (a[15] ^ bs[i][b]) : (a[31] ^ bs[i][b]);
        a = a << 1;
        if (isNarrow(op)) a = a & 32'h0000_FFFF;
        if (fb) a = a ^ poly;
      end
    return a;
  endfunction

  function automatic logic [31:0] refPost(logic [31:0] ctl, logic [31:0] v);
    logic [31:0] r;
    r = v;
    if (ctl[9]) r = r ^ (isNarrow(ctl[3:0]) ? 32'h0000_FFFF : 32'hFFFF_FFFF);
    if (ctl[8]) r = {flip8(r[31:24]), flip8(r[23:16]), flip8(r[15:8]), flip8(r[7:0])};
    return r;
  endfunction

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd0) mCtl = d & 32'h0000_73BF;
    else if (a == 2'd1) mAcc = d;
    else if (a == 2'd2) begin
      mAcc = refStep(mCtl, mAcc, d);
      mCtl[14:13] = 2'b00;
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic checkState(input string tag);
    logic [31:0] v;
    readReg(2'd1, v); check(tag, v, mAcc);
    readReg(2'd3, v); check(tag, v, refPost(mCtl, mAcc));
    readReg(2'd0, v); check(tag, v, mCtl);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    string msg;
    logic [3:0] ops [6];
    ops[0] = 4'h0; ops[1] = 4'h1; ops[2] = 4'h2; ops[3] = 4'h3; ops[4] = 4'h8; ops[5] = 4'h6;
    v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    readReg(2'd0, v); check("R1 ctrl", v, 32'h0);
    readReg(2'd1, v); check("R1 seed", v, 32'h0);
    readReg(2'd3, v); check("R1 result", v, 32'h0);

    // R2 R3 R5: CRC-32 poly 0x04C11DB7, all-ones start, 8-bit writes of "123456789"
    writeReg(2'd0, 32'h0000_7002);
    for (int i = 0; i < 9; i++) writeReg(2'd2, 32'h31 + i);
    readReg(2'd1, v); check("R2 crc32 check value", v, 32'h0376_E6E7);
    // R4 init field cleared after the run
    readReg(2'd0, v); check("R4 init cleared", v, 32'h0000_1002);

    // R2 R3: poly 0x1021 all ones, same string
    writeReg(2'd0, 32'h0000_7001);
    for (int i = 0; i < 9; i++) writeReg(2'd2, 32'h31 + i);
    readReg(2'd1, v); check("R2 crc16 check value", v, 32'h0000_29B1);

    // R8 end-around carry
    writeReg(2'd0, 32'h0000_4008);
    writeReg(2'd2, 32'hFFFF_0001);
    readReg(2'd1, v); check("R8 end-around carry", v, 32'h0000_0001);

    // R3 seed start and R10 seed load
    writeReg(2'd1, 32'hDEAD_BEEF);
    readReg(2'd1, v); check("R10 seed load", v, 32'hDEAD_BEEF);
    writeReg(2'd0, 32'h0000_0002);
    writeReg(2'd2, 32'h1234_5678);
    checkState("R3 seed start");

    // R9 result inversion and byte reversal leave seed raw
    writeReg(2'd0, 32'h0000_0302);
    checkState("R9 post-processing");

    // R11 undefined op and result-address write ignored
    v = mAcc;
    writeReg(2'd0, 32'h0000_0005);
    writeReg(2'd2, 32'hCAFE_F00D);
    readReg(2'd1, wrData); check("R11 undefined op", wrData, v);
    wrData = 32'h0;
    writeReg(2'd3, 32'h5555_AAAA);
    readReg(2'd1, v); check("R11 result write ignored", v, mAcc);
    writeReg(2'd0, 32'hFFFF_FFFF);
    readReg(2'd0, v); check("R11 ctrl reserved bits", v, 32'h0000_73BF);

    // R6 R7: directed swaps and reversal on a 32-bit CRC
    writeReg(2'd0, 32'h0000_40B3);
    writeReg(2'd2, 32'h0102_0304);
    checkState("R7 R6 swaps and reversal");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int r;
      logic [31:0] c;
      r = $urandom % 8;
      if (r < 2 || it == 0) begin
        c = $urandom & 32'h0000_13BF;
        c[3:0] = ops[($urandom % 12) < 11 ? ($urandom % 5) : 5];
        case ($urandom % 3)
          0: c[14:13] = 2'b00;
          1: c[14:13] = 2'b10;
          default: c[14:13] = 2'b11;
        endcase
        writeReg(2'd0, c);
      end else if (r == 2) begin
        writeReg(2'd1, $urandom);
      end
      writeReg(2'd2, $urandom);
      if (mCtl[3:0] == 4'h8) msg = "R8 random checksum";
      else if (mCtl[12]) msg = "R5 random byte-mode crc";
      else if (mCtl[5] || mCtl[4]) msg = "R7 random swapped crc";
      else if (mCtl[7]) msg = "R6 random reversed crc";
      else msg = "R2 random crc";
      checkState(msg);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule